// File: doc/BRIEF.md
# Per-Channel Trigger Cycle History with Daisy-Chain Readout

This block remembers, for each of four trigger channels, whether the channel fired in the current trigger cycle and in each of the three cycles before it. The history advances only when a once-per-cycle strobe is present. The sixteen remembered bits are packed into one 16-bit word. That word serves as the chip's contribution to a daisy-chained high-speed readout. A monitor copy of the word is also taken on the shared monitor capture tick.

Chips on a readout chain hand a token to one another through an active-low chain-enable signal. When this chip's readout is switched off, the incoming enable is passed straight to the outgoing enable. When readout is switched on, the chip counts the words it sends while its incoming enable is active. It asserts its outgoing enable once the count equals the programmed terminal count. A status triple and the running word count are brought out so that a control bus can read them.

Top module: `trig_hist_chain`

## Requirements
- R1: While reset is asserted, the history word, the monitor word and the word count are all zero.
- R2: Without `cycle_strobe`, the history word keeps its value whatever `fired` does.
- R3: On a clock edge with `cycle_strobe` high, `fired` becomes the current stage. Channel n of age slot s sits at bit 4*s+n of `hist_word`. Slot 3 (bits 15:12) is the current cycle, slot 2 the previous cycle, slot 1 the one before that, and slot 0 (bits 3:0) the oldest.
- R4: Each strobe moves every stage one cycle older. A bit leaves the word after the fourth strobe following its entry.
- R5: On an edge with `mon_capture` high, `mon_word` takes the history word as it stood before that edge. Otherwise `mon_word` holds.
- R6: With `rd_enable` low, `chain_out_n` equals `chain_in_n` combinationally and the word count stays 0.
- R7: With `rd_enable` high and `chain_in_n` low, each edge with `rd_word` high adds one to the count. The count stops at `term_count`.
- R8: With `rd_enable` high, `chain_out_n` is low exactly when `chain_in_n` is low and the count equals `term_count`.
- R9: An edge with `chain_in_n` high clears the count to 0.
- R10: `status` bit 0 is `chain_in_n`, bit 1 is `chain_out_n`, and bit 2 is `rd_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_strobe | input | 1 | One-tick pulse per trigger cycle; advances the history |
| fired | input | 4 | Fired state of each channel for the current cycle |
| mon_capture | input | 1 | Monitor capture tick |
| rd_enable | input | 1 | Readout enable for this chip |
| term_count | input | 4 | Number of words this chip sends |
| rd_word | input | 1 | One word transferred on the chain this tick |
| chain_in_n | input | 1 | Active-low chain enable from the previous chip |
| chain_out_n | output | 1 | Active-low chain enable to the next chip |
| cur_count | output | 4 | Current word count |
| status | output | 3 | {rd_enable, chain_out_n, chain_in_n} |
| hist_word | output | 16 | Packed four-cycle history |
| mon_word | output | 16 | Monitor copy of the packed history |

## Verification
The saturation and step properties assume that `term_count` does not change while a chain transfer is under way. The bench therefore programs `term_count` and `rd_enable` only while `chain_in_n` is inactive or the count is at rest. The history properties assume that `fired` is a defined level on every strobe edge, so the bench drives every input to a known value from time zero and changes it only on falling edges. A terminal count of zero with readout enabled is not a supported setting, and the stimulus never uses it.

// File: rtl/trig_hist_pkg.sv
package trig_hist_pkg;
    localparam int NCH_DEF   = 4;
    localparam int DEPTH_DEF = 4;
    localparam int CNT_W_DEF = 4;
    localparam int ST_IN_BIT  = 0;
    localparam int ST_OUT_BIT = 1;
    localparam int ST_EN_BIT  = 2;
    localparam int ST_W       = 3;
endpackage

// File: rtl/trig_hist_shift.sv
module trig_hist_shift
    import trig_hist_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int DEPTH = DEPTH_DEF,
    localparam int WW   = NCH * DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cycle_strobe,
    input  logic [NCH-1:0] fired,
    output logic [WW-1:0]  hist_word
);
    typedef struct packed {
        logic [DEPTH-1:0][NCH-1:0] stage;
    } hs_t;

    hs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cycle_strobe) begin
            r_d.stage[0] = fired;
            for (int k = 1; k < DEPTH; k++) begin
                r_d.stage[k] = r_q.stage[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Age a lands in slot DEPTH-1-a; channel n at offset n within the slot
    for (genvar a = 0; a < DEPTH; a++) begin : g_age
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            assign hist_word[(DEPTH-1-a)*NCH + n] = r_q.stage[a][n];
        end
    end

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_strobe |=> $stable(hist_word));
    a_r3_current_slot: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_strobe |=> hist_word[WW-1 -: NCH] == $past(fired));
    a_r4_age_moves: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_strobe |=> hist_word[WW-NCH-1:0] == $past(hist_word[WW-1:NCH]));
endmodule

// File: rtl/trig_hist_chain_ctl.sv
module trig_hist_chain_ctl
    import trig_hist_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_enable,
    input  logic [CNT_W-1:0] term_count,
    input  logic             rd_word,
    input  logic             chain_in_n,
    output logic             chain_out_n,
    output logic [CNT_W-1:0] cur_count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cc_t;

    cc_t r_d, r_q;
    logic reached;

    always_comb begin
        r_d = r_q;
        if (!rd_enable || chain_in_n) begin
            r_d.cnt = '0;
        end else if (rd_word && (r_q.cnt != term_count)) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reached     = !chain_in_n && (r_q.cnt == term_count);
    assign chain_out_n = rd_enable ? !reached : chain_in_n;
    assign cur_count   = r_q.cnt;

    a_r6_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_enable |=> cur_count == '0);
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_enable && !chain_in_n && rd_word && cur_count != term_count)
        |=> cur_count == $past(cur_count) + 1'b1);
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_enable && !chain_in_n && cur_count == term_count)
        |=> cur_count == $past(cur_count));
    a_r8_quiet_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_enable && chain_in_n) |-> chain_out_n);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        chain_in_n |=> cur_count == '0);
endmodule

// File: rtl/trig_hist_mon.sv
module trig_hist_mon
    import trig_hist_pkg::*;
#(
    parameter int WW = NCH_DEF * DEPTH_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_capture,
    input  logic [WW-1:0] word_in,
    output logic [WW-1:0] mon_word
);
    typedef struct packed {
        logic [WW-1:0] snap;
    } mn_t;

    mn_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (mon_capture) r_d.snap = word_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mon_word = r_q.snap;

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_capture |=> $stable(mon_word));
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        mon_capture |=> mon_word == $past(word_in));
endmodule

// File: rtl/trig_hist_chain.sv
module trig_hist_chain
    import trig_hist_pkg::*;
#(
    parameter int NCH   = NCH_DEF,
    parameter int DEPTH = DEPTH_DEF,
    parameter int CNT_W = CNT_W_DEF,
    localparam int WW   = NCH * DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_strobe,
    input  logic [NCH-1:0]   fired,
    input  logic             mon_capture,
    input  logic             rd_enable,
    input  logic [CNT_W-1:0] term_count,
    input  logic             rd_word,
    input  logic             chain_in_n,
    output logic             chain_out_n,
    output logic [CNT_W-1:0] cur_count,
    output logic [ST_W-1:0]  status,
    output logic [WW-1:0]    hist_word,
    output logic [WW-1:0]    mon_word
);
    trig_hist_shift #(.NCH(NCH), .DEPTH(DEPTH)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .cycle_strobe (cycle_strobe),
        .fired        (fired),
        .hist_word    (hist_word)
    );

    trig_hist_mon #(.WW(WW)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_capture (mon_capture),
        .word_in     (hist_word),
        .mon_word    (mon_word)
    );

    trig_hist_chain_ctl #(.CNT_W(CNT_W)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_enable   (rd_enable),
        .term_count  (term_count),
        .rd_word     (rd_word),
        .chain_in_n  (chain_in_n),
        .chain_out_n (chain_out_n),
        .cur_count   (cur_count)
    );

    always_comb begin
        status             = '0;
        status[ST_IN_BIT]  = chain_in_n;
        status[ST_OUT_BIT] = chain_out_n;
        status[ST_EN_BIT]  = rd_enable;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (hist_word == '0 && mon_word == '0 && cur_count == '0));
endmodule

// File: tb/trig_hist_chain_test.sv
module trig_hist_chain_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cycle_strobe = 1'b0;
    logic [3:0]  fired = 4'h0;
    logic        mon_capture = 1'b0;
    logic        rd_enable = 1'b0;
    logic [3:0]  term_count = 4'h0;
    logic        rd_word = 1'b0;
    logic        chain_in_n = 1'b1;
    logic        chain_out_n;
    logic [3:0]  cur_count;
    logic [2:0]  status;
    logic [15:0] hist_word;
    logic [15:0] mon_word;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trig_hist_chain uut (
        .clk(clk), .rst_n(rst_n), .cycle_strobe(cycle_strobe), .fired(fired),
        .mon_capture(mon_capture), .rd_enable(rd_enable), .term_count(term_count),
        .rd_word(rd_word), .chain_in_n(chain_in_n), .chain_out_n(chain_out_n),
        .cur_count(cur_count), .status(status), .hist_word(hist_word),
        .mon_word(mon_word)
    );

    // {fired[3:0], cycle_strobe, mon_capture}
    localparam int NV = 16;
    localparam logic [5:0] VEC [NV] = '{
        6'b1010_1_0, 6'b0101_1_0, 6'b1111_0_0, 6'b0011_1_1,
        6'b1000_0_1, 6'b0110_1_0, 6'b0001_1_0, 6'b1111_0_1,
        6'b1100_1_1, 6'b0000_1_0, 6'b1001_0_0, 6'b0111_1_1,
        6'b0010_1_0, 6'b1110_0_1, 6'b0100_1_0, 6'b1011_1_1
    };

    logic [3:0]  m_hist [4];
    logic [15:0] m_mon;

    function automatic logic [15:0] pack_model();
        logic [15:0] w;
        for (int a = 0; a < 4; a++) w[(3-a)*4 +: 4] = m_hist[a];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4; a++) m_hist[a] = 4'h0;
        m_mon = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 hist", 32'(hist_word), 32'h0);
        chk("R1 mon", 32'(mon_word), 32'h0);
        chk("R1 count", 32'(cur_count), 32'h0);
        chk("R10 status reset", 32'(status), 32'b011);
        rst_n = 1'b1;
        step();

        // Table walk: R2, R3, R5
        for (int i = 0; i < NV; i++) begin
            fired        = VEC[i][5:2];
            cycle_strobe = VEC[i][1];
            mon_capture  = VEC[i][0];
            if (VEC[i][0]) m_mon = pack_model();
            if (VEC[i][1]) begin
                for (int a = 3; a > 0; a--) m_hist[a] = m_hist[a-1];
                m_hist[0] = VEC[i][5:2];
            end
            step();
            if (VEC[i][1]) chk("R3 packed history", 32'(hist_word), 32'(pack_model()));
            else           chk("R2 hold without strobe", 32'(hist_word), 32'(pack_model()));
            chk("R5 monitor copy", 32'(mon_word), 32'(m_mon));
        end
        cycle_strobe = 1'b0;
        mon_capture  = 1'b0;

        // R4: a bit ages out after four strobes
        fired = 4'h9; cycle_strobe = 1'b1; step();
        fired = 4'h0; step(); step(); step();
        chk("R4 oldest slot", 32'(hist_word), 32'h0009);
        step();
        chk("R4 aged out", 32'(hist_word), 32'h0000);
        cycle_strobe = 1'b0;
        step();

        // R6: pass-through when disabled
        rd_enable = 1'b0; chain_in_n = 1'b0; rd_word = 1'b1; #1;
        chk("R6 pass low", 32'(chain_out_n), 32'h0);
        step();
        chk("R6 count idle", 32'(cur_count), 32'h0);
        chain_in_n = 1'b1; #1;
        chk("R6 pass high", 32'(chain_out_n), 32'h1);
        rd_word = 1'b0;
        step();

        // R7/R8: enabled, terminal count 3
        rd_enable = 1'b1; term_count = 4'd3; step();
        chain_in_n = 1'b0; #1;
        chk("R8 not yet", 32'(chain_out_n), 32'h1);
        chk("R10 status active", 32'(status), 32'b110);
        rd_word = 1'b1;
        step(); chk("R7 count 1", 32'(cur_count), 32'd1);
        chk("R8 high at 1", 32'(chain_out_n), 32'h1);
        step(); chk("R7 count 2", 32'(cur_count), 32'd2);
        step(); chk("R7 count 3", 32'(cur_count), 32'd3);
        chk("R8 asserted at tc", 32'(chain_out_n), 32'h0);
        chk("R10 status done", 32'(status), 32'b100);
        step(); chk("R7 saturate", 32'(cur_count), 32'd3);
        rd_word = 1'b0;
        chain_in_n = 1'b1; #1;
        chk("R8 released", 32'(chain_out_n), 32'h1);
        step(); chk("R9 clear", 32'(cur_count), 32'd0);

        // R9: clear part way; R7 hold without rd_word
        chain_in_n = 1'b0; rd_word = 1'b1; step();
        rd_word = 1'b0; step();
        chk("R7 hold without word", 32'(cur_count), 32'd1);
        chain_in_n = 1'b1; step();
        chk("R9 clear mid", 32'(cur_count), 32'd0);

        // R8: terminal count 1 boundary
        term_count = 4'd1; step();
        chain_in_n = 1'b0; rd_word = 1'b1; step();
        rd_word = 1'b0;
        chk("R8 tc one", 32'(chain_out_n), 32'h0);
        chain_in_n = 1'b1; step();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule